// File: doc/BRIEF.md
# Multi-mode timer output compare channel

This block is one output compare channel. It watches one of two external 16-bit up-counting timers and drives one output pin. A 3-bit mode field selects the behaviour:

- **Single-match modes:** force the pin low, force it high, or toggle it.
- **Dual-compare pulse modes:** produce a pulse that rises on the primary compare value and falls on the secondary one, either once or every timer period.
- **PWM modes:** double-buffered PWM, with or without fault shutdown.

Each timer supplies its count and a one-cycle period-match strobe. The strobe is high in the last cycle of the count before it returns to zero. The compare registers, the fault input and the control word come from the surrounding register logic. The control word is the mode plus the timer select, written with a strobe.

In the PWM modes the primary compare input is not used. The duty is held in an internal main latch, which is reloaded from the secondary compare input only at a period match, so a duty change never produces a glitch. In the fault-protected PWM mode, a low fault input tri-states the pin through its output-enable and latches a status flag. The flag is cleared only by rewriting a PWM mode while the fault input is high.

All outputs are registered. An input condition seen in one cycle shows at the outputs after the next rising clock edge.

Top module: `oc_channel`

## Requirements
- R1: After reset the pin is 0, the output-enable is 1, the fault flag and the interrupt are 0, the mode is 000 and timer A is selected.
- R2: A cycle with `ctl_wr` high loads the mode and `ctl_tsel`. In that cycle no compare action and no interrupt occur. Writing mode 000 or any mode 1xx clears the pin to 0. Writing 001 to 011 keeps the pin level. While the mode is 000 the pin stays 0.
- R3: With `ctl_tsel` = 0 the channel uses timer A's count and period strobe. With 1 it uses timer B's.
- R4: A match event is the first cycle in which the selected count equals the reference value, after a cycle in which it did not. In modes 001, 010 and 011 a primary match event sets the pin to 0, sets it to 1, or inverts it, respectively, and raises `irq` for one cycle. Otherwise the pin holds, including across a timer wrap.
- R5: In mode 100, a write arms the channel. The pin rises on a primary match event and falls on a secondary match event; both edges raise `irq`. Once the pulse has fallen, the pin stays 0 until mode 100 is written again.
- R6: Mode 101 behaves like mode 100 but re-arms every period for as long as the mode is held.
- R7: In modes 100 and 101, a pin that is still high at the selected period strobe is forced to 0. `irq` is raised only if a secondary match event occurs in that same cycle. If primary and secondary match events coincide while the pin is 0, the pin stays 0 and `irq` is raised. The pulse is then done.
- R8: In modes 110 and 111, each period strobe does three things: it copies `cmp_sec` into the duty latch, sets the pin to 1 if that value is nonzero and to 0 if it is zero, and raises `irq`. In any other cycle the pin goes to 0 when the count equals the duty latch. `cmp_pri` is ignored. Entering a PWM mode loads the duty latch from `cmp_sec`.
- R9: A change of `cmp_sec` in the middle of a PWM period does not move the current falling edge; it takes effect from the next period strobe.
- R10: In mode 111, a 0 on `fault_n` sets `fault_flag` at the next edge. While the flag is set, `pin_oe` is 0.
- R11: `fault_flag` clears only in a write cycle of mode 110 or 111 while `fault_n` is 1. In mode 110 `fault_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a_cnt | input | TW | Timer A count |
| tmr_a_wrap | input | 1 | Timer A period-match strobe |
| tmr_b_cnt | input | TW | Timer B count |
| tmr_b_wrap | input | 1 | Timer B period-match strobe |
| cmp_pri | input | TW | Primary compare value |
| cmp_sec | input | TW | Secondary compare value / PWM duty buffer |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_mode | input | 3 | Mode value written |
| ctl_tsel | input | 1 | Timer select written (0 = A, 1 = B) |
| fault_n | input | 1 | Active-low fault input |
| pin_out | output | 1 | Output pin value |
| pin_oe | output | 1 | Output enable (0 = high impedance) |
| fault_flag | output | 1 | Latched fault status |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the per-cycle rules on every cycle:
- mode 000 holds the pin low;
- a control write never raises an interrupt;
- a disarmed one-shot stays low;
- every PWM period strobe reloads the duty latch;
- the fault flag sets in mode 111 and only clears through a qualifying write.

Only the bench scenarios can show the full sequences. These are:
- pulse shapes across several periods, including a secondary value at, below or beyond the primary value and the period;
- edge detection against a prescaled timer that holds its count for two cycles;
- a duty change in mid-period;
- fault recovery ordering.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_OFF      = 3'b000,
    OC_LOW      = 3'b001,
    OC_HIGH     = 3'b010,
    OC_TOGGLE   = 3'b011,
    OC_ONESHOT  = 3'b100,
    OC_CONT     = 3'b101,
    OC_PWM      = 3'b110,
    OC_PWM_FLT  = 3'b111
  } oc_mode_e;

  function automatic logic is_pwm(input logic [2:0] m);
    return m[2:1] == 2'b11;
  endfunction

  function automatic logic is_pulse(input logic [2:0] m);
    return m[2:1] == 2'b10;
  endfunction

  // pin level that a write of mode m leaves behind
  function automatic logic entry_level(input logic [2:0] m, input logic cur);
    return (m == OC_OFF || m[2]) ? 1'b0 : cur;
  endfunction

  // pin level after a primary match in a single-match mode
  function automatic logic match_level(input logic [2:0] m, input logic cur);
    case (m)
      OC_LOW:    return 1'b0;
      OC_HIGH:   return 1'b1;
      OC_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/oc_tmr_sel.sv
module oc_tmr_sel #(
  parameter int TW = 16
) (
  input  logic          tsel,
  input  logic [TW-1:0] cnt_a,
  input  logic          wrap_a,
  input  logic [TW-1:0] cnt_b,
  input  logic          wrap_b,
  output logic [TW-1:0] cnt,
  output logic          wrap
);
  assign cnt  = tsel ? cnt_b  : cnt_a;
  assign wrap = tsel ? wrap_b : wrap_a;
endmodule

// File: rtl/oc_match_det.sv
module oc_match_det #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] ref_val,
  output logic          hit,
  output logic          evt
);
  logic hit_q;

  assign hit = (cnt == ref_val);
  assign evt = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end
endmodule

// File: rtl/oc_fault_ctl.sv
module oc_fault_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_q,
  input  logic       wr,
  input  logic [2:0] wr_mode,
  input  logic       fault_n,
  output logic       fault_flag
);
  import oc_pkg::*;

  logic clr, set;

  assign clr = wr && is_pwm(wr_mode) && fault_n;
  assign set = (mode_q == OC_PWM_FLT) && !fault_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   fault_flag <= 1'b0;
    else if (clr) fault_flag <= 1'b0;
    else if (set) fault_flag <= 1'b1;
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_a_cnt,
  input  logic          tmr_a_wrap,
  input  logic [TW-1:0] tmr_b_cnt,
  input  logic          tmr_b_wrap,
  input  logic [TW-1:0] cmp_pri,
  input  logic [TW-1:0] cmp_sec,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_tsel,
  input  logic          fault_n,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          fault_flag,
  output logic          irq
);
  localparam int NREF = 2;

  oc_mode_e      mode_q;
  logic          tsel_q;
  logic          armed_q;
  logic [TW-1:0] duty_q;

  logic [TW-1:0] sel_cnt;
  logic          sel_wrap;
  logic [TW-1:0] refs    [NREF];
  logic [NREF-1:0] hit_lvl;
  logic [NREF-1:0] hit_evt;
  logic          pri_evt, sec_evt, duty_hit;
  logic          pin_d, irq_d, armed_d, pulse_go;

  oc_tmr_sel #(.TW(TW)) u_sel (
    .tsel   (tsel_q),
    .cnt_a  (tmr_a_cnt),
    .wrap_a (tmr_a_wrap),
    .cnt_b  (tmr_b_cnt),
    .wrap_b (tmr_b_wrap),
    .cnt    (sel_cnt),
    .wrap   (sel_wrap)
  );

  assign refs[0] = cmp_pri;
  assign refs[1] = cmp_sec;

  for (genvar g = 0; g < NREF; g++) begin : g_det
    oc_match_det #(.TW(TW)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (sel_cnt),
      .ref_val (refs[g]),
      .hit     (hit_lvl[g]),
      .evt     (hit_evt[g])
    );
  end

  assign pri_evt  = hit_evt[0];
  assign sec_evt  = hit_evt[1];
  assign duty_hit = (sel_cnt == duty_q);
  assign pulse_go = (mode_q == OC_CONT) || armed_q;

  oc_fault_ctl u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .wr         (ctl_wr),
    .wr_mode    (ctl_mode),
    .fault_n    (fault_n),
    .fault_flag (fault_flag)
  );

  assign pin_oe = ~fault_flag;

  always_comb begin
    pin_d   = pin_out;
    irq_d   = 1'b0;
    armed_d = armed_q;
    if (ctl_wr) begin
      pin_d   = entry_level(ctl_mode, pin_out);
      armed_d = (ctl_mode == OC_ONESHOT);
    end else begin
      case (mode_q)
        OC_OFF: pin_d = 1'b0;
        OC_LOW, OC_HIGH, OC_TOGGLE: begin
          if (pri_evt) begin
            pin_d = match_level(mode_q, pin_out);
            irq_d = 1'b1;
          end
        end
        OC_ONESHOT, OC_CONT: begin
          if (pin_out && sel_wrap) begin
            pin_d   = 1'b0;
            irq_d   = sec_evt;
            armed_d = 1'b0;
          end else if (!pin_out && pri_evt && pulse_go) begin
            irq_d = 1'b1;
            if (sec_evt) armed_d = 1'b0;
            else         pin_d   = 1'b1;
          end else if (pin_out && sec_evt) begin
            pin_d   = 1'b0;
            irq_d   = 1'b1;
            armed_d = 1'b0;
          end
        end
        default: begin
          if (sel_wrap) begin
            pin_d = (cmp_sec != '0);
            irq_d = 1'b1;
          end else if (duty_hit) begin
            pin_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= OC_OFF;
      tsel_q  <= 1'b0;
      armed_q <= 1'b0;
      duty_q  <= '0;
      pin_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pin_out <= pin_d;
      irq     <= irq_d;
      armed_q <= armed_d;
      if (ctl_wr) begin
        mode_q <= oc_mode_e'(ctl_mode);
        tsel_q <= ctl_tsel;
        if (is_pwm(ctl_mode)) duty_q <= cmp_sec;
      end else if (is_pwm(mode_q) && sel_wrap) begin
        duty_q <= cmp_sec;
      end
    end
  end

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [2:0]    ctl_mode,
  input logic          fault_n,
  input logic [TW-1:0] cmp_sec,
  input logic [2:0]    mode_q,
  input logic          armed_q,
  input logic [TW-1:0] duty_q,
  input logic          sel_wrap,
  input logic          pin_out,
  input logic          fault_flag,
  input logic          irq
);
  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 && !ctl_wr) |=> !pin_out);

  // R2
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !irq);

  // R5
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b100 && !armed_q && !ctl_wr) |=> !pin_out);

  // R8
  pwm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:1] == 2'b11 && sel_wrap && !ctl_wr) |=> (duty_q == $past(cmp_sec)));

  // R10
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b111 && !fault_n) |=> fault_flag);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !(ctl_wr && ctl_mode[2:1] == 2'b11 && fault_n)) |=> fault_flag);
endmodule

bind oc_channel oc_channel_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_mode   (ctl_mode),
  .fault_n    (fault_n),
  .cmp_sec    (cmp_sec),
  .mode_q     (mode_q),
  .armed_q    (armed_q),
  .duty_q     (duty_q),
  .sel_wrap   (sel_wrap),
  .pin_out    (pin_out),
  .fault_flag (fault_flag),
  .irq        (irq)
);

// File: tb/sim_oc_channel.sv
module sim_oc_channel;
  localparam int TW = 16;
  localparam int PA = 19;
  localparam int PB = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] tmr_a_cnt = '0, tmr_b_cnt = '0;
  logic tmr_a_wrap = 1'b0, tmr_b_wrap = 1'b0;
  logic [TW-1:0] cmp_pri = '0, cmp_sec = '0;
  logic ctl_wr = 1'b0;
  logic [2:0] ctl_mode = 3'b000;
  logic ctl_tsel = 1'b0;
  logic fault_n = 1'b1;
  logic pin_out, pin_oe, fault_flag, irq;

  int checks = 0, failures = 0;
  bit done = 0;
  bit b_phase = 0;

  always #5 clk = ~clk;

  oc_channel #(.TW(TW)) u0 (.*);

  // timers: A counts every cycle, B every second cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      tmr_a_cnt = '0; tmr_b_cnt = '0; b_phase = 0;
      tmr_a_wrap = 0; tmr_b_wrap = 0;
    end else begin
      tmr_a_cnt  = (tmr_a_cnt == PA) ? '0 : tmr_a_cnt + 1'b1;
      tmr_a_wrap = (tmr_a_cnt == PA);
      b_phase = ~b_phase;
      if (!b_phase) tmr_b_cnt = (tmr_b_cnt == PB) ? '0 : tmr_b_cnt + 1'b1;
      tmr_b_wrap = (tmr_b_cnt == PB) && b_phase;
    end
  end

  // behavioural reference model
  int  m_mode = 0, m_duty = 0;
  bit  m_tsel = 0, m_pin = 0, m_irq = 0, m_flt = 0, m_armed = 0;
  bit  m_pprev = 0, m_sprev = 0, m_wr_last = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_duty = 0; m_tsel = 0; m_pin = 0; m_irq = 0;
      m_flt = 0; m_armed = 0; m_pprev = 0; m_sprev = 0; m_wr_last = 0;
    end else begin
      int  c;
      bit  w, pm, sm, pe, se;
      c  = m_tsel ? int'(tmr_b_cnt) : int'(tmr_a_cnt);
      w  = m_tsel ? tmr_b_wrap : tmr_a_wrap;
      pm = (c == int'(cmp_pri));
      sm = (c == int'(cmp_sec));
      pe = pm && !m_pprev;
      se = sm && !m_sprev;
      m_pprev = pm; m_sprev = sm;
      m_irq = 0;
      if (ctl_wr && ctl_mode >= 3'd6 && fault_n) m_flt = 0;
      else if (m_mode == 7 && !fault_n) m_flt = 1;
      m_wr_last = ctl_wr;
      if (ctl_wr) begin
        m_mode = int'(ctl_mode);
        m_tsel = ctl_tsel;
        if (m_mode == 0 || m_mode >= 4) m_pin = 0;
        m_armed = (m_mode == 4);
        if (m_mode >= 6) m_duty = int'(cmp_sec);
      end else if (m_mode == 0) begin
        m_pin = 0;
      end else if (m_mode <= 3) begin
        if (pe) begin
          m_irq = 1;
          m_pin = (m_mode == 1) ? 1'b0 : (m_mode == 2) ? 1'b1 : !m_pin;
        end
      end else if (m_mode <= 5) begin
        if (m_pin) begin
          if (w || se) begin m_pin = 0; m_irq = se; m_armed = 0; end
        end else if (pe && (m_mode == 5 || m_armed)) begin
          m_irq = 1;
          if (se) m_armed = 0; else m_pin = 1;
        end
      end else begin
        if (w) begin m_duty = int'(cmp_sec); m_pin = (cmp_sec != 0); m_irq = 1; end
        else if (c == m_duty) m_pin = 0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    string t;
    if (m_wr_last) t = "R2";
    else case (m_mode)
      0: t = "R2";
      1, 2, 3: t = "R4";
      4: t = "R5";
      5: t = "R6";
      default: t = "R8 R9";
    endcase
    if ((m_mode == 4 || m_mode == 5) && cmp_sec <= cmp_pri) t = {t, " R7"};
    if (m_tsel) t = {t, " R3"};
    return t;
  endfunction

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(mode_tag(), "pin_out", pin_out, m_pin);
      chk(mode_tag(), "irq", irq, m_irq);
      chk("R10 R11", "fault_flag", fault_flag, m_flt);
      chk("R10", "pin_oe", pin_oe, !m_flt);
    end
  end

  task automatic wr(input logic [2:0] m, input logic t);
    @(negedge clk);
    ctl_mode = m; ctl_tsel = t; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pin_out", pin_out, 1'b0);
    chk("R1", "pin_oe", pin_oe, 1'b1);
    chk("R1", "fault_flag", fault_flag, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1;
    run(10);
    // R4: single-match modes on timer A
    cmp_pri = 5;   wr(3'b010, 0); run(45);
    cmp_pri = 25;  wr(3'b001, 0); run(45);  // never reached: pin holds
    cmp_pri = 9;   run(45);
    cmp_pri = 3;   wr(3'b011, 0); run(65);
    // R3: toggle on prescaled timer B
    cmp_pri = 4;   wr(3'b011, 1); run(80);
    // R5: one-shot, then re-armed
    cmp_pri = 4; cmp_sec = 10; wr(3'b100, 0); run(60);
    wr(3'b100, 0); run(50);
    wr(3'b100, 1); run(60);
    // R6 / R7: continuous pulse variants
    wr(3'b101, 0); run(60);
    cmp_sec = 2;   run(60);
    cmp_pri = 6; cmp_sec = 6; run(50);
    cmp_pri = 4; cmp_sec = 30; run(50);
    cmp_sec = 2;   wr(3'b100, 0); run(50);
    // R8 / R9: PWM
    cmp_pri = 3; cmp_sec = 7; wr(3'b110, 0); run(50);
    run(6); cmp_sec = 12; run(40);
    cmp_sec = 0;   run(45);
    cmp_sec = PA;  run(45);
    cmp_sec = 25;  run(45);
    cmp_sec = 5;   wr(3'b110, 1); run(60);
    // R11: fault ignored in 110
    fault_n = 0; run(5); fault_n = 1; run(5);
    // R10 / R11: fault-protected PWM
    wr(3'b111, 0); run(30);
    fault_n = 0; run(3); fault_n = 1; run(30);
    wr(3'b000, 0); run(20);
    fault_n = 0; wr(3'b111, 0); run(5);
    fault_n = 1; run(10);
    wr(3'b111, 0); run(40);
    wr(3'b000, 0); run(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule